// File: doc/BRIEF.md
# Dual-Gain Token Readout Multiplexer Controller

This block is the digital control for reading out an analog front end with many channels, where every channel has a low-gain (x1) and a high-gain (x10) sampled value. A single token is shifted along two identical token chains, one per gain path. Each stage of a chain drives the read enable of its own channel. The two chains have one serial input, one shift clock and one clear in common, so they always hold the same state. A gain-select input then decides, without waiting for a clock, which of the two paths may drive the shared analog output. The path that is not selected is disabled.

A built-in sequencer runs one readout frame for each trigger. It counts a programmable delay from the trigger to the hold command, then asserts hold. It clears both chains, inserts exactly one token, and shifts that token across every channel and out of the tail. It then flags the end of the frame and drops hold. Only the low-gain chain's tail is brought out, as a serial output.

Top module: `rdmux_top`

## Requirements
- R1: While `rst_ni` is low, both chains are cleared at once, without a clock. All read enables, both drive enables, `hold_o`, `sr_out_o` and `frame_done_o` are low.
- R2: Count the rising edge that samples `trig_i` high in idle as edge 0. Channel n (0 to NCH-1) is then the only active channel between edge HOLD_DLY+2+n and the following edge. Bit n of a read-enable vector belongs to channel n, and at most one bit of a chain is ever set.
- R3: The x1 chain and the x10 chain hold identical contents on every cycle.
- R4: `sr_out_o` is high exactly while channel NCH-1 is active. On the next edge the token leaves, no channel is active, and `frame_done_o` is high for that one cycle.
- R5: With `gain_hi_i`=0, `rd_lo_o` carries the active channel and `rd_hi_o` is zero. With `gain_hi_i`=1 the roles swap. A change on `gain_hi_i` takes effect with no clock edge.
- R6: `drv_lo_o` is high only when `gain_hi_i`=0 and a channel is active, and `drv_hi_o` is high only when `gain_hi_i`=1 and a channel is active. The two drive enables are never high together, and `rd_lo_o` and `rd_hi_o` are never both nonzero.
- R7: `hold_o` rises at edge HOLD_DLY. It stays high through the frame-done cycle and falls at the edge after that cycle, so a channel is only ever active while hold is high.
- R8: A trigger that arrives while a frame is in progress is ignored: the frame's timing and outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift and sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Starts a readout frame when sampled high in idle |
| gain_hi_i | input | 1 | 0 selects the x1 path, 1 selects the x10 path |
| hold_o | output | 1 | Hold command that freezes the sampled values |
| rd_lo_o | output | NCH | Gated x1 read enables, one bit per channel |
| rd_hi_o | output | NCH | Gated x10 read enables, one bit per channel |
| drv_lo_o | output | 1 | x1 path drives the shared output (otherwise high impedance) |
| drv_hi_o | output | 1 | x10 path drives the shared output (otherwise high impedance) |
| sr_out_o | output | 1 | Tail of the x1 chain |
| frame_done_o | output | 1 | One-cycle end-of-frame flag |

## Verification
The checker watches properties that must hold on every cycle: the two chains stay equal, each chain holds at most one set bit, the token moves one step per clock, the chain empties after the tail and the frame-done flag follows, hold covers every active channel, and the two paths are never enabled together. The exact cycle at which each channel becomes active, the hold delay, the end of hold, and the fact that triggers arriving mid-frame are ignored can only be shown by the bench's frames, which count edges from the trigger. The bench also exercises the asynchronous effect of gain select, by toggling it between clock edges, and the effect of an asynchronous reset in the middle of a frame.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_HOLD,
        SEQ_RESET,
        SEQ_INJECT,
        SEQ_SHIFT,
        SEQ_DONE
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdmux_token_chain.sv
module rdmux_token_chain #(
    parameter int NCH = 18
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clr_i,
    input  logic           shift_i,
    input  logic           din_i,
    output logic [NCH-1:0] q_o
);

    logic [NCH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (clr_i) begin
            stage_d = '0;
        end else if (shift_i) begin
            stage_d = {stage_q[NCH-2:0], din_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q_o = stage_q;

endmodule

// File: rtl/rdmux_sequencer.sv
module rdmux_sequencer
    import rdmux_pkg::*;
#(
    parameter int NCH      = 18,
    parameter int HOLD_DLY = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic hold_o,
    output logic chain_clr_o,
    output logic chain_shift_o,
    output logic chain_din_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(max_int(NCH, HOLD_DLY) + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_DLY - 1);
    localparam logic [CNT_W-1:0] SHIFT_LAST = CNT_W'(NCH - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d         = seq_q;
        chain_clr_o   = 1'b0;
        chain_shift_o = 1'b0;
        chain_din_o   = 1'b0;
        done_o        = 1'b0;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (trig_i) begin
                    seq_d.st  = SEQ_HOLD;
                    seq_d.cnt = '0;
                end
            end
            SEQ_HOLD: begin
                if (seq_q.cnt == HOLD_LAST) begin
                    seq_d.st   = SEQ_RESET;
                    seq_d.hold = 1'b1;
                    seq_d.cnt  = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_RESET: begin
                chain_clr_o = 1'b1;
                seq_d.st    = SEQ_INJECT;
            end
            SEQ_INJECT: begin
                chain_din_o   = 1'b1;
                chain_shift_o = 1'b1;
                seq_d.st      = SEQ_SHIFT;
                seq_d.cnt     = '0;
            end
            SEQ_SHIFT: begin
                chain_shift_o = 1'b1;
                if (seq_q.cnt == SHIFT_LAST) begin
                    seq_d.st = SEQ_DONE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_DONE: begin
                done_o     = 1'b1;
                seq_d.hold = 1'b0;
                seq_d.st   = SEQ_IDLE;
            end
            default: begin
                seq_d = '{st: SEQ_IDLE, cnt: '0, hold: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0, hold: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hold_o = seq_q.hold;

endmodule

// File: rtl/rdmux_gain_sel.sv
module rdmux_gain_sel #(
    parameter int NCH = 18
) (
    input  logic           gain_hi_i,
    input  logic [NCH-1:0] lo_en_i,
    input  logic [NCH-1:0] hi_en_i,
    output logic [NCH-1:0] rd_lo_o,
    output logic [NCH-1:0] rd_hi_o,
    output logic           drv_lo_o,
    output logic           drv_hi_o
);

    always_comb begin
        rd_lo_o  = gain_hi_i ? '0 : lo_en_i;
        rd_hi_o  = gain_hi_i ? hi_en_i : '0;
        drv_lo_o = !gain_hi_i && (|lo_en_i);
        drv_hi_o = gain_hi_i && (|hi_en_i);
    end

endmodule

// File: rtl/rdmux_top.sv
module rdmux_top #(
    parameter int NCH      = 18,
    parameter int HOLD_DLY = 5
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           trig_i,
    input  logic           gain_hi_i,
    output logic           hold_o,
    output logic [NCH-1:0] rd_lo_o,
    output logic [NCH-1:0] rd_hi_o,
    output logic           drv_lo_o,
    output logic           drv_hi_o,
    output logic           sr_out_o,
    output logic           frame_done_o
);

    localparam int NPATH = 2;

    logic           chain_clr;
    logic           chain_shift;
    logic           chain_din;
    logic [NCH-1:0] chain_q [NPATH];
    logic [NCH-1:0] lo_q;
    logic [NCH-1:0] hi_q;

    rdmux_sequencer #(
        .NCH      (NCH),
        .HOLD_DLY (HOLD_DLY)
    ) i_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .trig_i        (trig_i),
        .hold_o        (hold_o),
        .chain_clr_o   (chain_clr),
        .chain_shift_o (chain_shift),
        .chain_din_o   (chain_din),
        .done_o        (frame_done_o)
    );

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        rdmux_token_chain #(
            .NCH (NCH)
        ) i_chain (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (chain_clr),
            .shift_i (chain_shift),
            .din_i   (chain_din),
            .q_o     (chain_q[p])
        );
    end

    assign lo_q     = chain_q[0];
    assign hi_q     = chain_q[1];
    assign sr_out_o = lo_q[NCH-1];

    rdmux_gain_sel #(
        .NCH (NCH)
    ) i_gsel (
        .gain_hi_i (gain_hi_i),
        .lo_en_i   (lo_q),
        .hi_en_i   (hi_q),
        .rd_lo_o   (rd_lo_o),
        .rd_hi_o   (rd_hi_o),
        .drv_lo_o  (drv_lo_o),
        .drv_hi_o  (drv_hi_o)
    );

endmodule

// File: rtl/rdmux_chk.sv
module rdmux_chk #(
    parameter int NCH = 18
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           gain_hi_i,
    input logic           hold_o,
    input logic [NCH-1:0] rd_lo_o,
    input logic [NCH-1:0] rd_hi_o,
    input logic           drv_lo_o,
    input logic           drv_hi_o,
    input logic           sr_out_o,
    input logic           frame_done_o,
    input logic [NCH-1:0] lo_q,
    input logic [NCH-1:0] hi_q
);

    AST_CHAINS_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_q == hi_q); // R3

    AST_ONE_TOKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lo_q)); // R2

    AST_TOKEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|lo_q) && !lo_q[NCH-1]) |=> (lo_q == ($past(lo_q) << 1))); // R2

    AST_TAIL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_q[NCH-1] |=> (lo_q == '0)); // R4

    AST_TAIL_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sr_out_o |=> frame_done_o); // R4

    AST_HI_PATH_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gain_hi_i && (|hi_q)) |-> ((rd_hi_o == hi_q) && (rd_lo_o == '0))); // R5

    AST_NO_DUAL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(drv_lo_o && drv_hi_o)); // R6

    AST_NO_DUAL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((|rd_lo_o) && (|rd_hi_o))); // R6

    AST_HOLD_COVERS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|lo_q) |-> hold_o); // R7

    AST_HOLD_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !hold_o); // R7

endmodule

bind rdmux_top rdmux_chk #(
    .NCH (NCH)
) i_rdmux_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gain_hi_i    (gain_hi_i),
    .hold_o       (hold_o),
    .rd_lo_o      (rd_lo_o),
    .rd_hi_o      (rd_hi_o),
    .drv_lo_o     (drv_lo_o),
    .drv_hi_o     (drv_hi_o),
    .sr_out_o     (sr_out_o),
    .frame_done_o (frame_done_o),
    .lo_q         (lo_q),
    .hi_q         (hi_q)
);

// File: tb/test_rdmux_top.sv
module test_rdmux_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 18;
    localparam int HOLD_DLY   = 4;

    logic           clk_i = 1'b0;
    logic           rst_ni = 1'b0;
    logic           trig_i = 1'b0;
    logic           gain_hi_i = 1'b0;
    logic           hold_o;
    logic [NCH-1:0] rd_lo_o;
    logic [NCH-1:0] rd_hi_o;
    logic           drv_lo_o;
    logic           drv_hi_o;
    logic           sr_out_o;
    logic           frame_done_o;

    int checks = 0;
    int errors = 0;

    rdmux_top #(
        .NCH      (NCH),
        .HOLD_DLY (HOLD_DLY)
    ) i_rdmux_top (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .trig_i       (trig_i),
        .gain_hi_i    (gain_hi_i),
        .hold_o       (hold_o),
        .rd_lo_o      (rd_lo_o),
        .rd_hi_o      (rd_hi_o),
        .drv_lo_o     (drv_lo_o),
        .drv_hi_o     (drv_hi_o),
        .sr_out_o     (sr_out_o),
        .frame_done_o (frame_done_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Active channel after the edge m edges past the trigger-sampling edge
    function automatic int exp_chan(input int m);
        int c;
        c = m - (HOLD_DLY + 2);
        return (c >= 0 && c < NCH) ? c : -1;
    endfunction

    function automatic logic [NCH-1:0] onehot(input int c);
        logic [NCH-1:0] v;
        v = '0;
        if (c >= 0) v[c] = 1'b1;
        return v;
    endfunction

    task automatic check_paths(input int c, input string tag);
        logic [NCH-1:0] vec;
        vec = onehot(c);
        check(rd_lo_o == (gain_hi_i ? '0 : vec), "R5", {tag, " rd_lo"}, 64'(rd_lo_o),
              64'(gain_hi_i ? '0 : vec));
        check(rd_hi_o == (gain_hi_i ? vec : '0), "R5", {tag, " rd_hi"}, 64'(rd_hi_o),
              64'(gain_hi_i ? vec : '0));
        check(drv_lo_o == (!gain_hi_i && c >= 0), "R6", {tag, " drv_lo"}, 64'(drv_lo_o),
              64'(!gain_hi_i && c >= 0));
        check(drv_hi_o == (gain_hi_i && c >= 0), "R6", {tag, " drv_hi"}, 64'(drv_hi_o),
              64'(gain_hi_i && c >= 0));
    endtask

    task automatic check_idle(input string req);
        check(hold_o == 1'b0, req, "idle hold", 64'(hold_o), 64'd0);
        check((rd_lo_o | rd_hi_o) == '0, req, "idle enables", 64'(rd_lo_o | rd_hi_o), 64'd0);
        check({drv_lo_o, drv_hi_o, sr_out_o, frame_done_o} == 4'b0, req, "idle flags",
              64'({drv_lo_o, drv_hi_o, sr_out_o, frame_done_o}), 64'd0);
    endtask

    // gmode: 0 random gain, 1 fixed x1, 2 fixed x10
    task automatic run_frame(input int gmode, input bit noisy);
        int c;
        @(negedge clk_i);
        trig_i = 1'b1;
        @(negedge clk_i);
        trig_i = 1'b0;
        for (int m = 0; m <= HOLD_DLY + 21; m++) begin
            gain_hi_i = (gmode == 0) ? 1'($urandom % 2) : (gmode == 2);
            trig_i = (noisy && m <= HOLD_DLY + 20) ? 1'($urandom % 2) : 1'b0;
            #1;
            c = exp_chan(m);
            check(hold_o == (m >= HOLD_DLY && m <= HOLD_DLY + 20), noisy ? "R8" : "R7",
                  "hold", 64'(hold_o), 64'(m >= HOLD_DLY && m <= HOLD_DLY + 20));
            check_paths(c, noisy ? "R8 R2" : "R2");
            check(sr_out_o == (c == NCH - 1), "R4", "serial out", 64'(sr_out_o),
                  64'(c == NCH - 1));
            check(frame_done_o == (m == HOLD_DLY + 20), "R4", "frame done",
                  64'(frame_done_o), 64'(m == HOLD_DLY + 20));
            if (gmode == 0) begin
                gain_hi_i = ~gain_hi_i;
                #1;
                check_paths(c, "R5 async toggle");
            end
            @(negedge clk_i);
        end
        trig_i = 1'b0;
        #1;
        check_idle("R2 after frame");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        #1;
        check_idle("R1");
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        check_idle("R1");

        run_frame(1, 1'b0);
        run_frame(2, 1'b0);
        run_frame(0, 1'b0);
        run_frame(0, 1'b1);

        // Asynchronous reset in the middle of the shift phase
        @(negedge clk_i);
        trig_i = 1'b1;
        @(negedge clk_i);
        trig_i = 1'b0;
        gain_hi_i = 1'b0;
        repeat (HOLD_DLY + 8) @(negedge clk_i);
        #1;
        check(rd_lo_o != '0, "R1", "token present before reset", 64'(rd_lo_o), 64'd1);
        rst_ni = 1'b0;
        #1;
        check_idle("R1 async");
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        check_idle("R1 after release");

        for (int f = 0; f < 4; f++) begin
            run_frame(0, f[0]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule